// File: doc/BRIEF.md
# Video DRAM Cycle-Type Decoder Core

This block is a synthesizable behavioural model of a small video DRAM core with a 4-bit data path. The controller drives the multiplexed address and the strobe pins. The row strobe `ras_n`, the column strobe `cas_n`, the write strobe `we_n`, the combined transfer/output-enable pin `dtoe_n` and the special-function select `dsf` are sampled on a free-running clock. When the row strobe falls, the levels of the other pins fix the kind of the whole row activation. The kinds are an ordinary access cycle (random or page mode), a colour-register cycle, or a flash-fill cycle.

In an access cycle, every falling column strobe reaches one word of the open row, so reads and writes can be mixed inside one activation. A colour-register cycle works the same way, except that the 4-bit static colour register takes the place of the array. A flash-fill cycle loads all columns of the addressed row in a single clock. The new value is the colour register, and a per-I/O mask sampled from the data pins picks which I/O planes are loaded. A watchdog counts the clocks during which the row strobe stays low. It raises a sticky error flag when a configurable limit is exceeded.

Top module: `vram_cycle_core`

## Requirements
- R1: When the row strobe falls with `cas_n`=1, `dtoe_n`=1 and `dsf`=0, the activation is an access cycle (`cycle_kind`=1). In that cycle, a column write stores `dq_in` at the latched row and column, and a column read shows the stored word on `dq_out` with `dq_oe`=1 from the clock after the column strobe falls, while `dtoe_n` is low. `cycle_kind` returns to 0 one clock after the row strobe is sampled high.
- R2: When the row strobe falls with `cas_n`=1, `dtoe_n`=1, `dsf`=1 and `we_n`=1, the activation is a colour-register cycle (`cycle_kind`=2).
- R3: When the row strobe falls with `cas_n`=1, `dtoe_n`=1, `dsf`=1 and `we_n`=0, the activation is a flash-fill cycle (`cycle_kind`=3). On that same clock, for every I/O i with `dq_in[i]`=1, all columns of the row given by the low address bits take colour bit i. I/Os with a mask bit of 0 and all other rows keep their data.
- R4: If `cas_n` or `dtoe_n` is low when the row strobe falls, the activation is idle (`cycle_kind`=0), and its column strobes change neither the array nor the colour register.
- R5: Within one access activation, any number of column strobes may address different columns of the row, in any mix of reads and writes, and each one takes effect.
- R6: The colour register resets to 0 and keeps its value through every cycle except a colour-register write.
- R7: A write is taken either when `we_n` is low as the column strobe falls (early) or when `we_n` falls later while the column strobe is still low (delayed). Each form stores exactly once, at the column latched at the strobe's fall.
- R8: In a colour-register cycle, a read returns the colour register, and a write updates only the colour register and leaves the array unchanged.
- R9: `ras_timeout` rises on the clock that samples the row strobe low for the (RAS_MAX_CLKS+1)-th time in a row. It stays high until reset. A column write on that same clock still takes effect.
- R10: After reset, `dq_oe`=0, `dq_out`=0, `cycle_kind`=0 and `ras_timeout`=0.
- R11: Column strobes inside a flash-fill cycle are ignored, and the row holds exactly the flash result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running sampling clock |
| rst_n | input | 1 | active-low synchronous reset |
| ras_n | input | 1 | row strobe, active low |
| cas_n | input | 1 | column strobe, active low |
| we_n | input | 1 | write strobe, active low |
| dtoe_n | input | 1 | transfer select at row fall, output enable afterwards |
| dsf | input | 1 | special-function select sampled at row fall |
| addr | input | ADDR_W | multiplexed row/column address |
| dq_in | input | DQ_W | write data, or flash mask at row fall |
| dq_out | output | DQ_W | read data, zero when not enabled |
| dq_oe | output | 1 | read data valid/drive enable |
| cycle_kind | output | 2 | 0 idle, 1 access, 2 colour register, 3 flash fill |
| ras_timeout | output | 1 | sticky row-strobe-low limit error |

## Verification
The row-strobe watchdog and a page-mode column write can act on the same clock edge. The bench holds one access activation open for exactly RAS_MAX_CLKS samples and then drops the column and write strobes, so that the next edge is both the first over-limit sample and an early-write strobe. The flag must be low just before that edge and high just after it, and a read in a later activation must return the word written on the limit edge. A second overlap places a column write inside a flash-fill activation and requires that the row hold only the masked colour pattern afterwards.

// File: rtl/vram_pkg.sv
package vram_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_ACCESS = 2'd1,
      CYC_COLOR  = 2'd2,
      CYC_FLASH  = 2'd3
   } cyc_e;

   // Activation kind chosen from the pin levels present as the row strobe falls
   function automatic cyc_e decode_cycle(input logic cas_n, input logic dtoe_n,
                                         input logic we_n, input logic dsf);
      if (!cas_n || !dtoe_n) return CYC_IDLE;
      if (!dsf)              return CYC_ACCESS;
      if (we_n)              return CYC_COLOR;
      return CYC_FLASH;
   endfunction

endpackage

// File: rtl/vram_strobe_ctl.sv
module vram_strobe_ctl
   import vram_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int ROW_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              dtoe_n,
   input  logic              dsf,
   input  logic [ADDR_W-1:0] addr,
   output cyc_e              cyc,
   output logic [ROW_W-1:0]  row_q,
   output logic [ADDR_W-1:0] col_sel,
   output logic              ras_fall,
   output logic              col_fall,
   output logic              wr_go
);

   logic              ras_q, cas_q, we_q;
   logic              active, wrote;
   logic [ADDR_W-1:0] col_q;
   logic              dly_wr;

   assign ras_fall = ras_q & ~ras_n;
   assign col_fall = active & ~ras_n & cas_q & ~cas_n;
   assign dly_wr   = active & ~ras_n & ~cas_n & ~cas_q & we_q & ~we_n & ~wrote;
   assign wr_go    = (col_fall & ~we_n) | dly_wr;
   assign col_sel  = col_fall ? addr : col_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_q  <= 1'b1;
         cas_q  <= 1'b1;
         we_q   <= 1'b1;
         active <= 1'b0;
         wrote  <= 1'b0;
         cyc    <= CYC_IDLE;
         row_q  <= '0;
         col_q  <= '0;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         we_q  <= we_n;
         if (ras_fall) begin
            active <= 1'b1;
            cyc    <= decode_cycle(cas_n, dtoe_n, we_n, dsf);
            row_q  <= addr[ROW_W-1:0];
         end else if (ras_n) begin
            active <= 1'b0;
            cyc    <= CYC_IDLE;
         end
         if (cas_n)      wrote <= 1'b0;
         else if (wr_go) wrote <= 1'b1;
         if (col_fall)   col_q <= addr;
      end
   end

   AST_RAS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> (cyc == CYC_IDLE)); // R1

endmodule

// File: rtl/vram_plane_array.sv
module vram_plane_array #(
   parameter int DQ_W = 4,
   parameter int COLS = 512,
   parameter int ROWS = 4,
   localparam int COL_W = $clog2(COLS),
   localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flash_go,
   input  logic [ROW_W-1:0] flash_row,
   input  logic [DQ_W-1:0]  flash_mask,
   input  logic [DQ_W-1:0]  flash_val,
   input  logic             wr_go,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [COL_W-1:0] wr_col,
   input  logic [DQ_W-1:0]  wr_data,
   input  logic [ROW_W-1:0] rd_row,
   input  logic [COL_W-1:0] rd_col,
   output logic [DQ_W-1:0]  rd_data
);

   // One storage plane per I/O; a row of a plane is one wide register
   for (genvar p = 0; p < DQ_W; p++) begin : g_plane
      logic [COLS-1:0] mem [ROWS];

      always_ff @(posedge clk) begin
         if (flash_go && flash_mask[p])
            mem[flash_row] <= {COLS{flash_val[p]}};
         else if (wr_go)
            mem[wr_row][wr_col] <= wr_data[p];
      end

      assign rd_data[p] = mem[rd_row][rd_col];
   end

   AST_FLASH_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_go && wr_go)); // R11

endmodule

// File: rtl/vram_ras_watch.sv
module vram_ras_watch #(
   parameter int RAS_MAX_CLKS = 200,
   localparam int CNT_W = $clog2(RAS_MAX_CLKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   output logic timeout
);

   logic [CNT_W-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
         timeout <= 1'b0;
      end else begin
         if (ras_n)
            low_cnt <= '0;
         else if (low_cnt != CNT_W'(RAS_MAX_CLKS))
            low_cnt <= low_cnt + 1'b1;
         if (!ras_n && low_cnt == CNT_W'(RAS_MAX_CLKS))
            timeout <= 1'b1;
      end
   end

   AST_CNT_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> (low_cnt == '0)); // R9
   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> timeout); // R9
   AST_TIMEOUT_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> !$past(ras_n)); // R9

endmodule

// File: rtl/vram_cycle_core.sv
module vram_cycle_core
   import vram_pkg::*;
#(
   parameter int DQ_W         = 4,
   parameter int COLS         = 512,
   parameter int ROWS         = 4,
   parameter int RAS_MAX_CLKS = 200,
   localparam int COL_W  = $clog2(COLS),
   localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int ADDR_W = COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              dtoe_n,
   input  logic              dsf,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic [1:0]        cycle_kind,
   output logic              ras_timeout
);

   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("COLS must be a power of two of at least 2");
   end
   if ((ROWS & (ROWS - 1)) != 0 || ROWS < 1) begin : g_bad_rows
      $error("ROWS must be a power of two");
   end
   if (ROW_W > COL_W) begin : g_bad_addr
      $error("row address must fit in the column address width");
   end
   if (DQ_W < 1 || RAS_MAX_CLKS < 1) begin : g_bad_misc
      $error("DQ_W and RAS_MAX_CLKS must be positive");
   end

   cyc_e              cyc;
   logic [ROW_W-1:0]  row_q;
   logic [ADDR_W-1:0] col_sel;
   logic              ras_fall, col_fall, wr_go;
   logic              flash_go, arr_wr, color_wr, rd_go;
   logic [DQ_W-1:0]   color_q, rd_data_q, arr_rd;
   logic              rd_hold;

   vram_strobe_ctl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .dtoe_n   (dtoe_n),
      .dsf      (dsf),
      .addr     (addr),
      .cyc      (cyc),
      .row_q    (row_q),
      .col_sel  (col_sel),
      .ras_fall (ras_fall),
      .col_fall (col_fall),
      .wr_go    (wr_go)
   );

   assign flash_go = ras_fall && (decode_cycle(cas_n, dtoe_n, we_n, dsf) == CYC_FLASH);
   assign arr_wr   = wr_go && (cyc == CYC_ACCESS);
   assign color_wr = wr_go && (cyc == CYC_COLOR);
   assign rd_go    = col_fall && we_n && (cyc == CYC_ACCESS || cyc == CYC_COLOR);

   vram_plane_array #(.DQ_W(DQ_W), .COLS(COLS), .ROWS(ROWS)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .flash_go   (flash_go),
      .flash_row  (addr[ROW_W-1:0]),
      .flash_mask (dq_in),
      .flash_val  (color_q),
      .wr_go      (arr_wr),
      .wr_row     (row_q),
      .wr_col     (col_sel),
      .wr_data    (dq_in),
      .rd_row     (row_q),
      .rd_col     (col_sel),
      .rd_data    (arr_rd)
   );

   vram_ras_watch #(.RAS_MAX_CLKS(RAS_MAX_CLKS)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_n   (ras_n),
      .timeout (ras_timeout)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         color_q   <= '0;
         rd_data_q <= '0;
         rd_hold   <= 1'b0;
      end else begin
         if (color_wr) color_q <= dq_in;
         if (rd_go) begin
            rd_data_q <= (cyc == CYC_COLOR) ? color_q : arr_rd;
            rd_hold   <= 1'b1;
         end else if (cas_n || wr_go) begin
            rd_hold   <= 1'b0;
         end
      end
   end

   assign dq_oe      = rd_hold & ~dtoe_n;
   assign dq_out     = dq_oe ? rd_data_q : '0;
   assign cycle_kind = cyc;

   AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> $stable(color_q)); // R6
   AST_FLASH_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      flash_go |=> (cycle_kind == 2'd3)); // R3
   AST_FLASH_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (cycle_kind == 2'd3) |-> !dq_oe); // R11

endmodule

// File: tb/vram_cycle_core_tb.sv
module vram_cycle_core_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DQ_W = 4;
   localparam int COLS = 512;
   localparam int ROWS = 4;
   localparam int RMAX = 40;
   localparam int AW   = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dtoe_n = 1'b1, dsf = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [3:0]    dq_in = '0;
   logic [3:0]    dq_out;
   logic          dq_oe;
   logic [1:0]    cycle_kind;
   logic          ras_timeout;

   always #(CLK_PERIOD/2) clk = ~clk;

   vram_cycle_core #(.DQ_W(DQ_W), .COLS(COLS), .ROWS(ROWS), .RAS_MAX_CLKS(RMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .dtoe_n(dtoe_n), .dsf(dsf), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
      .dq_oe(dq_oe), .cycle_kind(cycle_kind), .ras_timeout(ras_timeout)
   );

   typedef struct {
      logic [3:0] exp;
      string      req;
   } item_t;

   item_t      sbq[$];
   logic [3:0] refm [ROWS][COLS];
   logic [3:0] ref_color;
   int         n_chk = 0;
   int         n_fail = 0;
   logic       oe_prev = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected word per rising dq_oe
   initial forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (dq_oe && !oe_prev) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R1 unexpected read output", int'(dq_out), 0);
         end else begin
            item_t it;
            it = sbq.pop_front();
            check(dq_out === it.exp, it.req, int'(dq_out), int'(it.exp));
         end
      end
      oe_prev = dq_oe;
   end

   task automatic ras_open(input int row, input logic dsf_v, input logic we_v,
                           input logic cas_v, input logic dtoe_v, input logic [3:0] dq);
      @(negedge clk);
      addr = AW'(row); dsf = dsf_v; we_n = we_v; cas_n = cas_v; dtoe_n = dtoe_v;
      dq_in = dq; ras_n = 1'b0;
      @(negedge clk);
      dsf = 1'b0; we_n = 1'b1; cas_n = 1'b1; dtoe_n = 1'b1;
   endtask

   task automatic ras_close();
      @(negedge clk);
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dtoe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic col_write(input int col, input logic [3:0] data, input bit early);
      @(negedge clk);
      addr = AW'(col);
      if (early) begin
         dq_in = data; we_n = 1'b0; cas_n = 1'b0;
      end else begin
         we_n = 1'b1; cas_n = 1'b0;
         @(negedge clk);
         we_n = 1'b0; dq_in = data; addr = '0;
      end
      @(negedge clk);
      cas_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic col_read(input int col, input logic [3:0] exp, input string req);
      item_t it;
      @(negedge clk);
      addr = AW'(col); dtoe_n = 1'b0; cas_n = 1'b0;
      it.exp = exp; it.req = req;
      sbq.push_back(it);
      @(negedge clk);
      @(negedge clk);
      cas_n = 1'b1; dtoe_n = 1'b1;
   endtask

   task automatic flash_ref(input int row, input logic [3:0] mask);
      for (int c = 0; c < COLS; c++)
         refm[row][c] = (refm[row][c] & ~mask) | (ref_color & mask);
   endtask

   task automatic do_flash(input int row, input logic [3:0] mask);
      ras_open(row, 1'b1, 1'b0, 1'b1, 1'b1, mask);
      check(cycle_kind == 2'd3, "R3 flash kind", int'(cycle_kind), 3);
      flash_ref(row, mask);
      ras_close();
   endtask

   task automatic set_color(input logic [3:0] val, input bit early);
      ras_open(0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
      check(cycle_kind == 2'd2, "R2 colour kind", int'(cycle_kind), 2);
      col_write(3, val, early);
      ras_close();
      ref_color = val;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      ref_color = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(dq_oe == 1'b0, "R10 dq_oe reset", int'(dq_oe), 0);
      check(dq_out == 4'h0, "R10 dq_out reset", int'(dq_out), 0);
      check(cycle_kind == 2'd0, "R10 cycle_kind reset", int'(cycle_kind), 0);
      check(ras_timeout == 1'b0, "R10 timeout reset", int'(ras_timeout), 0);

      // Known contents: colour 0, flash every row with a full mask
      set_color(4'h0, 1'b1);
      for (int r = 0; r < ROWS; r++) do_flash(r, 4'hF);

      // R1 / R5 / R7 page mode on row 1
      ras_open(1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      check(cycle_kind == 2'd1, "R1 access kind", int'(cycle_kind), 1);
      col_write(5, 4'hA, 1'b1);   refm[1][5]   = 4'hA;
      col_write(511, 4'h3, 1'b1); refm[1][511] = 4'h3;
      col_write(200, 4'hC, 1'b0); refm[1][200] = 4'hC;
      col_read(5, refm[1][5], "R5 page read col 5");
      col_read(200, refm[1][200], "R7 delayed write col 200");
      col_read(511, refm[1][511], "R5 page read last column");
      col_read(0, refm[1][0], "R1 untouched column");
      col_write(5, 4'h6, 1'b1);   refm[1][5] = 4'h6;
      col_read(5, refm[1][5], "R5 mixed rewrite col 5");
      ras_close();
      check(cycle_kind == 2'd0, "R1 idle after row strobe rise", int'(cycle_kind), 0);

      // R8 colour register write and read, array untouched
      set_color(4'b1010, 1'b0);
      ras_open(0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(77, ref_color, "R8 colour register read");
      ras_close();
      ras_open(0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(3, refm[0][3], "R8 array untouched by colour write");
      ras_close();

      // R3 / R11 partial-mask flash of row 1 with a column write inside
      ras_open(1, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0101);
      check(cycle_kind == 2'd3, "R3 flash kind masked", int'(cycle_kind), 3);
      flash_ref(1, 4'b0101);
      col_write(7, 4'hF, 1'b1);
      ras_close();
      ras_open(1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(5, refm[1][5], "R3 masked flash col 5");
      col_read(200, refm[1][200], "R3 masked flash col 200");
      col_read(511, refm[1][511], "R3 masked flash col 511");
      col_read(0, refm[1][0], "R3 masked flash col 0");
      col_read(7, refm[1][7], "R11 column write in flash ignored");
      ras_close();

      // R3 full-row flash; other rows kept; R6 colour retained
      do_flash(2, 4'hF);
      ras_open(2, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(0, refm[2][0], "R3 full flash col 0");
      col_read(256, refm[2][256], "R3 full flash col 256");
      col_read(511, refm[2][511], "R3 full flash col 511");
      ras_close();
      ras_open(3, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(5, refm[3][5], "R3 other row kept");
      ras_close();
      ras_open(0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(1, ref_color, "R6 colour held across cycles");
      ras_close();

      // R4 idle activations ignore column strobes
      ras_open(3, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
      check(cycle_kind == 2'd0, "R4 idle with column strobe low", int'(cycle_kind), 0);
      col_write(9, 4'h6, 1'b1);
      ras_close();
      ras_open(3, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
      check(cycle_kind == 2'd0, "R4 idle with transfer select low", int'(cycle_kind), 0);
      col_write(10, 4'h5, 1'b1);
      ras_close();
      ras_open(3, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
      col_write(11, 4'h9, 1'b1);
      ras_close();
      ras_open(3, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(9, refm[3][9], "R4 idle write ignored col 9");
      col_read(10, refm[3][10], "R4 idle write ignored col 10");
      ras_close();
      ras_open(0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(2, ref_color, "R4 colour unchanged by idle write");
      ras_close();

      // R9 row-strobe limit, with a write on the very limit edge
      ras_open(2, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      repeat (RMAX - 1) @(negedge clk);
      check(ras_timeout == 1'b0, "R9 no flag at limit", int'(ras_timeout), 0);
      addr = AW'(20); dq_in = 4'h9; we_n = 1'b0; cas_n = 1'b0;
      @(negedge clk);
      check(ras_timeout == 1'b1, "R9 flag one sample past limit", int'(ras_timeout), 1);
      cas_n = 1'b1; we_n = 1'b1;
      refm[2][20] = 4'h9;
      ras_close();
      check(ras_timeout == 1'b1, "R9 flag sticky", int'(ras_timeout), 1);
      ras_open(2, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
      col_read(20, refm[2][20], "R9 write on limit edge kept");
      ras_close();

      repeat (4) @(negedge clk);
      check(sbq.size() == 0, "R1 every read produced output", sbq.size(), 0);
      finish_run();
   end

endmodule